// File: doc/BRIEF.md
# Keyed Flow Hash Unit

This block turns a flow descriptor into two hashes for a receive flow-steering table. The descriptor is a set of 32-bit dwords. Dword 0 is the flow word, which carries the flow type, pool and VLAN information. The remaining dwords are folded together by XOR into one compressed common dword. Two 32-bit keys then decide, bit position by bit position, how shifted copies of that dword are combined. The bucket key drives one accumulator, the signature key drives another, and positions set in both keys feed a shared common accumulator.

Each request produces two results. The signature word carries the signature hash in its upper half and the bucket hash in its lower half; it is built from the unmasked dwords and both keys. The exact-match bucket index is built only from the bucket key and from dwords first ANDed with a per-dword mask. It is 13 bits wide, enough to address an 8K-bucket table.

A request is a one-cycle `start` pulse with all inputs valid. Both keys are captured at that pulse. Results appear with a `done` pulse exactly two cycles later. A new request may be issued on every cycle.

Top module: `fh_flow_hash`

## Requirements
- R1: For `bkt_idx`, every descriptor dword i (dword i = `desc_in[32*i+31:32*i]`) is ANDed with mask dword i (same position in `mask_in`) before use, so any descriptor bit whose mask bit is 0 has no effect on `bkt_idx`. An all-zero mask gives `bkt_idx` = 0.
- R2: The common dword is the XOR of dwords 1 to NUM_DW-1 and is independent of their order. Dword 0 is the flow word. For `sig_word` the dwords are used unmasked.
- R3: Let hi = common ^ flow ^ (flow >> 16) and lo = common with its 16-bit halves swapped. For each n in 0..15, key bit n selects term lo >> n and key bit n+16 selects term hi >> n. A term whose bit is set in both keys goes to the common accumulator. A term set only in the bucket key goes to the bucket accumulator. A term set only in the signature key goes to the signature accumulator, shifted left by (16-n) instead of shifted right.
- R4: lo is XORed with flow ^ (flow << 16) only after position 0, so this change affects positions 1 to 15 and never position 0.
- R5: `sig_word[15:0]` = (bucket ^ common)[15:0], and `sig_word[31:16]` = (signature ^ (common << 16))[31:16].
- R6: `bkt_idx` uses only the bucket key: every set bucket-key bit sends its term to one accumulator. The result is truncated to its low 13 bits, and the signature key has no effect on it.
- R7: `done` is high exactly two cycles after each `start`, and only then. Requests on consecutive cycles each give their own result on consecutive cycles.
- R8: Both keys are sampled in the `start` cycle. A key change in any later cycle does not alter that request's result.
- R9: After reset `done`, `sig_word` and `bkt_idx` are 0. The outputs hold their last value in every cycle without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; descriptor, mask and keys valid |
| desc_in | input | NUM_DW*32 | Descriptor dwords, dword 0 (flow word) in the low bits |
| mask_in | input | NUM_DW*32 | Mask dwords for the exact-match path, same layout |
| bkt_key | input | 32 | Bucket hash key |
| sig_key | input | 32 | Signature hash key |
| done | output | 1 | Result valid pulse |
| sig_word | output | 32 | Signature hash (upper half) and bucket hash (lower half) |
| bkt_idx | output | 13 | Exact-match bucket index |

## Verification
The hardest behaviour to observe is the late folding of the flow word into the low word. Any key bit at position 1 or above hides it. Two directed cases expose it instead: a nonzero flow word paired with a key that has only bit 0 set, in each key in turn. Both must give zero, and folding at the wrong point gives a nonzero value. Random keys and descriptors are then compared against an independent model that loops over the bit positions. Key sampling is exercised by changing both keys in the cycle after `start`.

// File: rtl/fh_pkg.sv
package fh_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t swap_halves(input word_t w);
    return {w[HALF_W-1:0], w[WORD_W-1:HALF_W]};
  endfunction
endpackage

// File: rtl/fh_fold.sv
module fh_fold
  import fh_pkg::*;
#(
  parameter int NUM_DW = 11
) (
  input  logic [NUM_DW*WORD_W-1:0] desc,
  input  logic [NUM_DW*WORD_W-1:0] mask,
  output word_t                    common_raw,
  output word_t                    common_msk,
  output word_t                    flow_msk
);
  localparam int LAST = NUM_DW - 1;

  word_t raw_acc [NUM_DW];
  word_t msk_acc [NUM_DW];

  assign raw_acc[0] = '0;
  assign msk_acc[0] = '0;

  generate
    for (genvar i = 1; i < NUM_DW; i++) begin : g_dw
      assign raw_acc[i] = raw_acc[i-1] ^ desc[i*WORD_W +: WORD_W];
      assign msk_acc[i] = msk_acc[i-1] ^ (desc[i*WORD_W +: WORD_W] & mask[i*WORD_W +: WORD_W]);
    end
  endgenerate

  assign common_raw = raw_acc[LAST];
  assign common_msk = msk_acc[LAST];
  assign flow_msk   = desc[WORD_W-1:0] & mask[WORD_W-1:0];
endmodule

// File: rtl/fh_keyed_mix.sv
module fh_keyed_mix
  import fh_pkg::*;
#(
  parameter bit DUAL = 1'b1
) (
  input  word_t common,
  input  word_t flow,
  input  word_t kb,
  input  word_t ks,
  output word_t res
);
  localparam int NPOS = HALF_W;
  localparam int NTERM = 2 * NPOS;

  word_t ks_eff;
  word_t hi_w, lo_first, lo_rest;
  word_t cm_t [NTERM];
  word_t bk_t [NTERM];
  word_t sg_t [NTERM];
  word_t cm_acc, bk_acc, sg_acc;

  assign ks_eff   = DUAL ? ks : '0;
  assign hi_w     = common ^ flow ^ (flow >> HALF_W);
  assign lo_first = swap_halves(common);
  assign lo_rest  = lo_first ^ flow ^ (flow << HALF_W);

  generate
    for (genvar n = 0; n < NPOS; n++) begin : g_pos
      word_t lo_n;
      if (n == 0) begin : g_first
        assign lo_n = lo_first;
      end else begin : g_rest
        assign lo_n = lo_rest;
      end
      assign cm_t[2*n]   = (kb[n] & ks_eff[n])    ? (lo_n >> n) : '0;
      assign bk_t[2*n]   = (kb[n] & ~ks_eff[n])   ? (lo_n >> n) : '0;
      assign sg_t[2*n]   = (~kb[n] & ks_eff[n])   ? (lo_n << (HALF_W - n)) : '0;
      assign cm_t[2*n+1] = (kb[n+HALF_W] & ks_eff[n+HALF_W])  ? (hi_w >> n) : '0;
      assign bk_t[2*n+1] = (kb[n+HALF_W] & ~ks_eff[n+HALF_W]) ? (hi_w >> n) : '0;
      assign sg_t[2*n+1] = (~kb[n+HALF_W] & ks_eff[n+HALF_W]) ? (hi_w << (HALF_W - n)) : '0;
    end
  endgenerate

  always_comb begin
    cm_acc = '0;
    bk_acc = '0;
    sg_acc = '0;
    for (int t = 0; t < NTERM; t++) begin
      cm_acc ^= cm_t[t];
      bk_acc ^= bk_t[t];
      sg_acc ^= sg_t[t];
    end
    if (DUAL)
      res = {(sg_acc[WORD_W-1:HALF_W] ^ cm_acc[HALF_W-1:0]),
             (bk_acc[HALF_W-1:0] ^ cm_acc[HALF_W-1:0])};
    else
      res = bk_acc;
  end
endmodule

// File: rtl/fh_flow_hash.sv
module fh_flow_hash
  import fh_pkg::*;
#(
  parameter int NUM_DW   = 11,
  parameter int BKT_BITS = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NUM_DW*WORD_W-1:0] desc_in,
  input  logic [NUM_DW*WORD_W-1:0] mask_in,
  input  logic [WORD_W-1:0]        bkt_key,
  input  logic [WORD_W-1:0]        sig_key,
  output logic                     done,
  output logic [WORD_W-1:0]        sig_word,
  output logic [BKT_BITS-1:0]      bkt_idx
);
  word_t common_raw, common_msk, flow_msk;
  logic  v1;
  word_t com_raw_q, com_msk_q, flow_raw_q, flow_msk_q, kb_q, ks_q;
  word_t sig_res, bkt_res;

  fh_fold #(.NUM_DW(NUM_DW)) u_fold (
    .desc       (desc_in),
    .mask       (mask_in),
    .common_raw (common_raw),
    .common_msk (common_msk),
    .flow_msk   (flow_msk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1         <= 1'b0;
      com_raw_q  <= '0;
      com_msk_q  <= '0;
      flow_raw_q <= '0;
      flow_msk_q <= '0;
      kb_q       <= '0;
      ks_q       <= '0;
    end else begin
      v1 <= start;
      if (start) begin
        com_raw_q  <= common_raw;
        com_msk_q  <= common_msk;
        flow_raw_q <= desc_in[WORD_W-1:0];
        flow_msk_q <= flow_msk;
        kb_q       <= bkt_key;
        ks_q       <= sig_key;
      end
    end
  end

  fh_keyed_mix #(.DUAL(1'b1)) u_sig_mix (
    .common (com_raw_q),
    .flow   (flow_raw_q),
    .kb     (kb_q),
    .ks     (ks_q),
    .res    (sig_res)
  );

  fh_keyed_mix #(.DUAL(1'b0)) u_bkt_mix (
    .common (com_msk_q),
    .flow   (flow_msk_q),
    .kb     (kb_q),
    .ks     (ks_q),
    .res    (bkt_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      sig_word <= '0;
      bkt_idx  <= '0;
    end else begin
      done <= v1;
      if (v1) begin
        sig_word <= sig_res;
        bkt_idx  <= bkt_res[BKT_BITS-1:0];
      end
    end
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 done);
  assert_no_spurious_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(sig_word) && $stable(bkt_idx)));
  assert_zero_mask_R1: assert property (@(posedge clk) disable iff (rst)
    (start && mask_in == '0) |-> ##2 (bkt_idx == '0));
  assert_zero_keys_R3: assert property (@(posedge clk) disable iff (rst)
    (v1 && kb_q == '0 && ks_q == '0) |=> (done && sig_word == '0 && bkt_idx == '0));
endmodule

// File: tb/test_fh_flow_hash.sv
module test_fh_flow_hash;
  localparam int NUM_DW = 11;
  localparam int W = 32;
  localparam int BB = 13;
  localparam int NV = 6;

  localparam logic [31:0] TBL_FLOW [NV] = '{32'h0000_0000, 32'h8001_0abc, 32'hffff_ffff,
                                           32'h1234_5678, 32'h00a5_5a00, 32'hdead_0001};
  localparam logic [31:0] TBL_SEED [NV] = '{32'h0000_0001, 32'h1357_9bdf, 32'hffff_0000,
                                           32'h0f0f_f0f0, 32'h7654_3210, 32'h8000_0000};
  localparam logic [31:0] TBL_MSEED[NV] = '{32'hffff_ffff, 32'hff00_ff00, 32'h0000_ffff,
                                           32'hffff_ffff, 32'h3c3c_c3c3, 32'h0000_0000};
  localparam logic [31:0] TBL_KB   [NV] = '{32'h0001_0000, 32'h5a1c_39e7, 32'hffff_ffff,
                                           32'h0000_8001, 32'h2b64_d70c, 32'hc003_1ef4};
  localparam logic [31:0] TBL_KS   [NV] = '{32'h0000_0000, 32'h93f2_0a5d, 32'hffff_ffff,
                                           32'h8001_0000, 32'h61a8_4f33, 32'h0c30_e1b7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NUM_DW*W-1:0] desc_in = '0;
  logic [NUM_DW*W-1:0] mask_in = '0;
  logic [W-1:0] bkt_key = '0;
  logic [W-1:0] sig_key = '0;
  logic done;
  logic [W-1:0] sig_word;
  logic [BB-1:0] bkt_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'hace1_2468;

  always #2 clk = ~clk;

  fh_flow_hash #(.NUM_DW(NUM_DW), .BKT_BITS(BB)) i_fh_flow_hash (
    .clk(clk), .rst(rst), .start(start), .desc_in(desc_in), .mask_in(mask_in),
    .bkt_key(bkt_key), .sig_key(sig_key), .done(done), .sig_word(sig_word), .bkt_idx(bkt_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xfold(input logic [NUM_DW*W-1:0] d, input logic [NUM_DW*W-1:0] m);
    logic [31:0] x = '0;
    for (int i = 1; i < NUM_DW; i++) x ^= d[i*W +: W] & m[i*W +: W];
    return x;
  endfunction

  // model: walks positions in order, bucket-only when dual is 0
  function automatic logic [31:0] model(input logic [31:0] com, input logic [31:0] flow,
                                        input logic [31:0] kb, input logic [31:0] ks, input bit dual);
    logic [31:0] hi, lo, c, b, s, k2;
    k2 = dual ? ks : 32'h0;
    hi = com ^ flow ^ (flow >> 16);
    lo = {com[15:0], com[31:16]};
    c = 0; b = 0; s = 0;
    for (int n = 0; n < 16; n++) begin
      if (n == 1) lo = lo ^ flow ^ (flow << 16);
      if (kb[n] && k2[n]) c ^= lo >> n;
      else if (kb[n]) b ^= lo >> n;
      else if (k2[n]) s ^= lo << (16 - n);
      if (kb[n+16] && k2[n+16]) c ^= hi >> n;
      else if (kb[n+16]) b ^= hi >> n;
      else if (k2[n+16]) s ^= hi << (16 - n);
    end
    if (!dual) return b;
    return ((b ^ c) & 32'h0000_ffff) | ((s ^ (c << 16)) & 32'hffff_0000);
  endfunction

  function automatic logic [NUM_DW*W-1:0] gen(input logic [31:0] flow, input logic [31:0] seed);
    logic [NUM_DW*W-1:0] d;
    d[W-1:0] = flow;
    for (int i = 1; i < NUM_DW; i++)
      d[i*W +: W] = (seed << (i % 7)) ^ (32'h9e37_79b9 * i) ^ {seed[15:0], seed[31:16]};
    return d;
  endfunction

  function automatic logic [NUM_DW*W-1:0] genm(input logic [31:0] mseed);
    logic [NUM_DW*W-1:0] m;
    for (int i = 0; i < NUM_DW; i++) m[i*W +: W] = (i % 2 == 0) ? mseed : ~mseed;
    return m;
  endfunction

  function automatic logic [31:0] exp_sig(input logic [NUM_DW*W-1:0] d, input logic [31:0] kb, input logic [31:0] ks);
    return model(xfold(d, '1), d[W-1:0], kb, ks, 1'b1);
  endfunction

  function automatic logic [31:0] exp_bkt(input logic [NUM_DW*W-1:0] d, input logic [NUM_DW*W-1:0] m,
                                          input logic [31:0] kb);
    return model(xfold(d, m), d[W-1:0] & m[W-1:0], kb, 32'h0, 1'b0) & 32'h0000_1fff;
  endfunction

  task automatic run(input string req, input logic [NUM_DW*W-1:0] d, input logic [NUM_DW*W-1:0] m,
                     input logic [31:0] kb, input logic [31:0] ks);
    @(negedge clk);
    start = 1'b1; desc_in = d; mask_in = m; bkt_key = kb; sig_key = ks;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check({req, " done"}, {31'b0, done}, 32'h1);
    check({req, " sig"}, sig_word, exp_sig(d, kb, ks));
    check({req, " bkt"}, {19'b0, bkt_idx}, exp_bkt(d, m, kb));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NUM_DW*W-1:0] d, d2, m;
    logic [31:0] s1, b1, kb0, ks0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset done", {31'b0, done}, 32'h0);
    check("R9 reset sig", sig_word, 32'h0);
    check("R9 reset bkt", {19'b0, bkt_idx}, 32'h0);
    rst = 1'b0;

    // vector table (R3, R5, R6, R1)
    for (int v = 0; v < NV; v++)
      run("R3 R5 R6 table", gen(TBL_FLOW[v], TBL_SEED[v]), genm(TBL_MSEED[v]), TBL_KB[v], TBL_KS[v]);

    // R3: hand case, common = 1, bucket key bit 16 -> 1
    d = '0; d[W +: W] = 32'h1;
    run("R3 hand", d, '1, 32'h0001_0000, 32'h0);
    check("R3 hand literal sig", sig_word, 32'h0000_0001);
    check("R3 hand literal bkt", {19'b0, bkt_idx}, 32'h1);

    // R4: flow word must not reach position 0
    d = '0; d[W-1:0] = 32'h0000_1234;
    run("R4 bucket bit0", d, '1, 32'h1, 32'h0);
    check("R4 bucket bit0 literal", sig_word, 32'h0);
    check("R4 bucket bit0 idx", {19'b0, bkt_idx}, 32'h0);
    run("R4 sig bit0", d, '1, 32'h0, 32'h1);
    check("R4 sig bit0 literal", sig_word, 32'h0);

    // R2: order of dwords 1..N-1 does not matter
    d = gen(32'h4242_0007, 32'hbeef_cafe);
    run("R2 order a", d, '1, 32'h3d5a_9c17, 32'hc1e0_4b6a);
    s1 = sig_word;
    d2 = d;
    d2[W +: W] = d[2*W +: W]; d2[2*W +: W] = d[W +: W];
    d2[5*W +: W] = d[9*W +: W]; d2[9*W +: W] = d[5*W +: W];
    run("R2 order b", d2, '1, 32'h3d5a_9c17, 32'hc1e0_4b6a);
    check("R2 order invariant", sig_word, s1);

    // R1: masked-off bits ignored by bkt_idx
    m = genm(32'hf0f0_0ff0);
    run("R1 base", d, m, 32'h7e21_b3c9, 32'h0);
    b1 = {19'b0, bkt_idx};
    run("R1 flip masked", d ^ ~m, m, 32'h7e21_b3c9, 32'h0);
    check("R1 masked bits ignored", {19'b0, bkt_idx}, b1);
    run("R1 zero mask", d, '0, 32'hffff_ffff, 32'h0);
    check("R1 zero mask literal", {19'b0, bkt_idx}, 32'h0);

    // R6: signature key has no effect on bkt_idx
    run("R6 ks a", d, '1, 32'h9a3c_5e71, 32'h0);
    b1 = {19'b0, bkt_idx};
    run("R6 ks b", d, '1, 32'h9a3c_5e71, 32'hffff_ffff);
    check("R6 sig key ignored", {19'b0, bkt_idx}, b1);

    // R8: keys change right after start
    kb0 = 32'h1b2c_3d4e; ks0 = 32'he4d3_c2b1;
    @(negedge clk);
    start = 1'b1; desc_in = d; mask_in = '1; bkt_key = kb0; sig_key = ks0;
    @(negedge clk);
    start = 1'b0; bkt_key = ~kb0; sig_key = ~ks0;
    @(negedge clk);
    check("R8 sig old keys", sig_word, exp_sig(d, kb0, ks0));
    check("R8 bkt old keys", {19'b0, bkt_idx}, exp_bkt(d, '1, kb0));

    // R7: back-to-back requests
    @(negedge clk);
    start = 1'b1; desc_in = gen(32'h1, 32'h11); mask_in = '1; bkt_key = 32'h0f0f_0f0f; sig_key = 32'h00ff_00ff;
    @(negedge clk);
    desc_in = gen(32'h2, 32'h22);
    @(negedge clk);
    start = 1'b0; desc_in = gen(32'h3, 32'h33);
    check("R7 b2b first done", {31'b0, done}, 32'h1);
    check("R7 b2b first", sig_word, exp_sig(gen(32'h1, 32'h11), 32'h0f0f_0f0f, 32'h00ff_00ff));
    @(negedge clk);
    check("R7 b2b second done", {31'b0, done}, 32'h1);
    check("R7 b2b second", sig_word, exp_sig(gen(32'h2, 32'h22), 32'h0f0f_0f0f, 32'h00ff_00ff));
    s1 = sig_word; b1 = {19'b0, bkt_idx};

    // R9: hold when idle, R7: no done without start
    repeat (3) begin
      @(negedge clk);
      check("R7 idle done", {31'b0, done}, 32'h0);
      check("R9 hold sig", sig_word, s1);
      check("R9 hold bkt", {19'b0, bkt_idx}, b1);
    end

    // R3 R4 R5 R6: random keys and descriptors against the model
    for (int r = 0; r < 40; r++) begin
      logic [NUM_DW*W-1:0] rd, rm;
      logic [31:0] rkb, rks;
      for (int i = 0; i < NUM_DW; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} * 32'h0001_9661 + 32'h3c6e_f35f;
        rd[i*W +: W] = lfsr;
        rm[i*W +: W] = lfsr ^ {lfsr[7:0], lfsr[31:8]};
      end
      lfsr = lfsr * 32'h0001_9661 + 32'h3c6e_f35f; rkb = lfsr;
      lfsr = lfsr * 32'h0001_9661 + 32'h3c6e_f35f; rks = lfsr;
      run("R3 R4 R5 random", rd, rm, rkb, rks);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule